// File: doc/BRIEF.md
# Configurable Multi-Output Logic Cell

The block is one programmable logic cell that sits behind a product-term array. It receives four sum-of-products terms and a set of global control lines. It holds a single storage bit that behaves as a D, T or JK flip-flop. Static configuration inputs give each sum a job. A sum can feed the storage bit's data, K, preset, reset or clock input. It can also be passed straight out as combinational logic, or used as the pad output enable or a buried feedback term.

All state sits in one system clock domain, `clk`. The cell clock is chosen from sum C, sum D or the global clock line with optional inversion. That source is sampled on `clk`, and the storage bit updates on the `clk` edge at which the sampled source is first seen high after being low. Preset and reset do not wait for a cell clock edge. They act on the next `clk` edge. A global type line can switch the storage bit between load (D) and count (T) behaviour while the cell runs.

There is no data stream in this cell. Every port is a plain level-sampled control or logic signal, so the cell has no valid/ready handshake and no back-pressure.

Top module: `lcc_cell`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the storage bit is 0. With `cfg_osel_i`=0 and `cfg_d_i`=0, every `out_o` bit reads 0, `oe_o` reads 1 and `fb_o` reads 0.
- R2: The cell clock source is chosen in this order. Sum C (`sum_i[2]`) is used when `cfg_c_i`=0. Otherwise sum D (`sum_i[3]`) is used when `cfg_d_i`=0. Otherwise the source is `gclk_i` XOR `gclk_inv_i`. The storage bit changes only on the `clk` edge where the sampled source is 1 after being 0 on the previous edge, or when a preset or reset is active. The sampled history is taken as 1 after reset.
- R3: In D behaviour, a cell clock edge loads the data term. The data term is sum A (`sum_i[0]`) when `cfg_a_i`=0, and 0 when `cfg_a_i`=1.
- R4: In T behaviour, a cell clock edge inverts the storage bit when the data term is 1 and keeps it when the data term is 0.
- R5: In JK behaviour (`cfg_kind_i`=2), J is the data term. K is sum B (`sum_i[1]`) when `cfg_b_i`=0, and 0 otherwise. On a cell clock edge, J/K = 0/0 holds, 1/0 sets, 0/1 clears and 1/1 inverts the bit.
- R6: When `cfg_dyn_i`=0, the behaviour comes from `cfg_kind_i`: 0 is D, 1 is T, 2 is JK and 3 is D. When `cfg_dyn_i`=1, `g_tmode_i`=1 selects T and `g_tmode_i`=0 selects D, whatever `cfg_kind_i` holds.
- R7: A preset sets the storage bit to 1 on the next `clk` edge, with or without a cell clock edge. The preset is active when `g_preset_i` is 1, or when `cfg_b_i`=1 and sum B is 1.
- R8: A reset clears the storage bit on the next `clk` edge and wins over a preset. The reset is active when `g_reset_i` is 1, or when `cfg_c_i`=1 and sum C is 1.
- R9: Output k shows the storage bit when `cfg_osel_i[k]`=0. When `cfg_osel_i[k]`=1 it shows sum k, but only if that sum is set to pass through (`cfg_a_i`=1 for k=0, `cfg_b_i`=2 for k=1, `cfg_c_i`=2 for k=2). Otherwise it shows 0.
- R10: `oe_o` follows sum D when `cfg_d_i`=1 and is 1 for any other `cfg_d_i` value.
- R11: `fb_o` follows sum D when `cfg_d_i`=2 and shows the storage bit otherwise, including while `oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sum_i | input | 4 | Sums A..D from the product-term array, bit 0 = A |
| gclk_i | input | 1 | Global cell clock line |
| gclk_inv_i | input | 1 | Inverts the global clock line before edge detection |
| g_preset_i | input | 1 | Global preset |
| g_reset_i | input | 1 | Global reset |
| g_tmode_i | input | 1 | Global run-time type select, 1 = T, 0 = D |
| cfg_dyn_i | input | 1 | 1 = type taken from `g_tmode_i` |
| cfg_kind_i | input | 2 | Static type: 0 D, 1 T, 2 JK, 3 D |
| cfg_a_i | input | 1 | Sum A job: 0 data, 1 pass-through |
| cfg_b_i | input | 2 | Sum B job: 0 K, 1 preset, 2/3 pass-through |
| cfg_c_i | input | 2 | Sum C job: 0 clock, 1 reset, 2/3 pass-through |
| cfg_d_i | input | 2 | Sum D job: 0 clock, 1 output enable, 2/3 feedback |
| cfg_osel_i | input | OUT_N (3) | Per output: 0 storage bit, 1 pass-through sum |
| out_o | output | OUT_N (3) | Cell outputs |
| oe_o | output | 1 | Output enable of the attached pad; 0 means high impedance |
| fb_o | output | 1 | Buried feedback node |

## Verification
The assertions assume that the configuration and the global lines are sampled as stable levels on `clk`. They also assume that a cell clock edge exists only as a 0-then-1 change between two sampled cycles. No property reasons about events shorter than one `clk` period. The stimulus changes every input only at the falling edge of `clk`, so each value is held for a whole period. The configuration changes only between test phases. Where a property needs a quiet cycle to prove the bit holds, the stimulus provides one by repeating the clock-source values, with preset and reset inactive.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  localparam int SUM_N  = 4;
  localparam int ROLE_W = 2;

  typedef enum logic [1:0] {
    KIND_D  = 2'd0,
    KIND_T  = 2'd1,
    KIND_JK = 2'd2,
    KIND_DX = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    BJOB_K    = 2'd0,
    BJOB_SET  = 2'd1,
    BJOB_PASS = 2'd2,
    BJOB_PAS2 = 2'd3
  } bjob_e;

  typedef enum logic [1:0] {
    CJOB_CLK  = 2'd0,
    CJOB_CLR  = 2'd1,
    CJOB_PASS = 2'd2,
    CJOB_PAS2 = 2'd3
  } cjob_e;

  typedef enum logic [1:0] {
    DJOB_CLK = 2'd0,
    DJOB_OE  = 2'd1,
    DJOB_FB  = 2'd2,
    DJOB_FB2 = 2'd3
  } djob_e;

endpackage

// File: rtl/lcc_clk_pick.sv
module lcc_clk_pick (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sum_c,
  input  logic          sum_d,
  input  logic          gclk,
  input  logic          ginv,
  input  lcc_pkg::cjob_e c_job,
  input  lcc_pkg::djob_e d_job,
  output logic          fire
);
  logic src;
  logic src_seen;

  always_comb begin
    if (c_job == lcc_pkg::CJOB_CLK)      src = sum_c;
    else if (d_job == lcc_pkg::DJOB_CLK) src = sum_d;
    else                                 src = gclk ^ ginv;
  end

  // history starts high so a source held high through reset gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_seen <= 1'b1;
    else        src_seen <= src;
  end

  assign fire = src & ~src_seen;
endmodule

// File: rtl/lcc_store.sv
module lcc_store (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  lcc_pkg::kind_e kind,
  input  logic           dt,
  input  logic           kin,
  input  logic           set,
  input  logic           clr,
  output logic           q
);
  logic nxt;

  always_comb begin
    unique case (kind)
      lcc_pkg::KIND_T:  nxt = q ^ dt;
      lcc_pkg::KIND_JK: begin
        unique case ({dt, kin})
          2'b00:   nxt = q;
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = ~q;
        endcase
      end
      default:          nxt = dt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (set)  q <= 1'b1;
    else if (fire) q <= nxt;
  end
endmodule

// File: rtl/lcc_route.sv
module lcc_route #(
  parameter int OUT_N = 3
) (
  input  logic [OUT_N-1:0] sums,
  input  logic [OUT_N-1:0] pass_ok,
  input  logic [OUT_N-1:0] osel,
  input  logic             q,
  output logic [OUT_N-1:0] outs
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_out
    assign outs[k] = osel[k] ? (pass_ok[k] & sums[k]) : q;
  end
endmodule

// File: rtl/lcc_cell.sv
module lcc_cell #(
  parameter int OUT_N = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [lcc_pkg::SUM_N-1:0]     sum_i,
  input  logic                          gclk_i,
  input  logic                          gclk_inv_i,
  input  logic                          g_preset_i,
  input  logic                          g_reset_i,
  input  logic                          g_tmode_i,
  input  logic                          cfg_dyn_i,
  input  logic [lcc_pkg::ROLE_W-1:0]    cfg_kind_i,
  input  logic                          cfg_a_i,
  input  logic [lcc_pkg::ROLE_W-1:0]    cfg_b_i,
  input  logic [lcc_pkg::ROLE_W-1:0]    cfg_c_i,
  input  logic [lcc_pkg::ROLE_W-1:0]    cfg_d_i,
  input  logic [OUT_N-1:0]              cfg_osel_i,
  output logic [OUT_N-1:0]              out_o,
  output logic                          oe_o,
  output logic                          fb_o
);
  import lcc_pkg::*;

  localparam int PASS_N = 3;

  kind_e kind_cfg, kind_use;
  bjob_e b_job;
  cjob_e c_job;
  djob_e d_job;
  logic  fire, q_r, dt, kin, set, clr;
  logic [PASS_N-1:0] pass_all;

  assign kind_cfg = kind_e'(cfg_kind_i);
  assign b_job    = bjob_e'(cfg_b_i);
  assign c_job    = cjob_e'(cfg_c_i);
  assign d_job    = djob_e'(cfg_d_i);

  always_comb begin
    if (cfg_dyn_i) kind_use = g_tmode_i ? KIND_T : KIND_D;
    else           kind_use = kind_cfg;
  end

  assign dt  = ~cfg_a_i & sum_i[0];
  assign kin = (b_job == BJOB_K) & sum_i[1];
  assign set = g_preset_i | ((b_job == BJOB_SET) & sum_i[1]);
  assign clr = g_reset_i  | ((c_job == CJOB_CLR) & sum_i[2]);

  assign pass_all[0] = cfg_a_i;
  assign pass_all[1] = cfg_b_i[1];
  assign pass_all[2] = cfg_c_i[1];

  lcc_clk_pick u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .sum_c (sum_i[2]),
    .sum_d (sum_i[3]),
    .gclk  (gclk_i),
    .ginv  (gclk_inv_i),
    .c_job (c_job),
    .d_job (d_job),
    .fire  (fire)
  );

  lcc_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .kind  (kind_use),
    .dt    (dt),
    .kin   (kin),
    .set   (set),
    .clr   (clr),
    .q     (q_r)
  );

  lcc_route #(.OUT_N(OUT_N)) u_route (
    .sums    (sum_i[OUT_N-1:0]),
    .pass_ok (pass_all[OUT_N-1:0]),
    .osel    (cfg_osel_i),
    .q       (q_r),
    .outs    (out_o)
  );

  assign oe_o = (d_job == DJOB_OE) ? sum_i[3] : 1'b1;
  assign fb_o = cfg_d_i[1] ? sum_i[3] : q_r;
endmodule

// File: rtl/lcc_cell_chk.sv
module lcc_cell_chk #(
  parameter int OUT_N = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       sum_i,
  input logic             gclk_i,
  input logic             gclk_inv_i,
  input logic             g_preset_i,
  input logic             g_reset_i,
  input logic [1:0]       cfg_b_i,
  input logic [1:0]       cfg_c_i,
  input logic [1:0]       cfg_d_i,
  input logic [OUT_N-1:0] cfg_osel_i,
  input logic [OUT_N-1:0] out_o,
  input logic             oe_o,
  input logic             fb_o,
  input logic             q
);
  logic clr_c, set_c;
  assign clr_c = g_reset_i  | (cfg_c_i == 2'd1 && sum_i[2]);
  assign set_c = g_preset_i | (cfg_b_i == 2'd1 && sum_i[1]);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_c |=> (q == 1'b0));

  assert_preset_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_c && !clr_c) |=> (q == 1'b1));

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_c && !clr_c && $stable(sum_i[3:2]) && $stable(gclk_i) &&
     $stable(gclk_inv_i) && $stable(cfg_c_i) && $stable(cfg_d_i)) |=> $stable(q));

  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_d_i != 2'd1) |-> oe_o);

  assert_fb_buried_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_d_i[1] == 1'b0) |-> (fb_o == q));

  assert_fb_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_d_i[1] == 1'b1) |-> (fb_o == sum_i[3]));

  assert_out_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_osel_i[0] == 1'b0) |-> (out_o[0] == q));
endmodule

bind lcc_cell lcc_cell_chk #(.OUT_N(OUT_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sum_i      (sum_i),
  .gclk_i     (gclk_i),
  .gclk_inv_i (gclk_inv_i),
  .g_preset_i (g_preset_i),
  .g_reset_i  (g_reset_i),
  .cfg_b_i    (cfg_b_i),
  .cfg_c_i    (cfg_c_i),
  .cfg_d_i    (cfg_d_i),
  .cfg_osel_i (cfg_osel_i),
  .out_o      (out_o),
  .oe_o       (oe_o),
  .fb_o       (fb_o),
  .q          (q_r)
);

// File: tb/tb_lcc_cell.sv
`timescale 1ns/1ps
module tb_lcc_cell;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [3:0] sum_i;
  logic gclk_i, gclk_inv_i, g_preset_i, g_reset_i, g_tmode_i, cfg_dyn_i, cfg_a_i;
  logic [1:0] cfg_kind_i, cfg_b_i, cfg_c_i, cfg_d_i;
  logic [2:0] cfg_osel_i;
  logic [2:0] out_o;
  logic oe_o, fb_o;

  int total = 0;
  int bad = 0;
  string focus = "R1";

  lcc_cell dut (
    .clk(clk), .rst_n(rst_n), .sum_i(sum_i), .gclk_i(gclk_i),
    .gclk_inv_i(gclk_inv_i), .g_preset_i(g_preset_i), .g_reset_i(g_reset_i),
    .g_tmode_i(g_tmode_i), .cfg_dyn_i(cfg_dyn_i), .cfg_kind_i(cfg_kind_i),
    .cfg_a_i(cfg_a_i), .cfg_b_i(cfg_b_i), .cfg_c_i(cfg_c_i), .cfg_d_i(cfg_d_i),
    .cfg_osel_i(cfg_osel_i), .out_o(out_o), .oe_o(oe_o), .fb_o(fb_o)
  );

  // behavioural reference: one storage bit and one remembered clock sample
  int q_m = 0;
  int prev_m = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      q_m = 0; prev_m = 1;
    end else begin
      int src, fire, d, k, pre, clr, kind;
      if (cfg_c_i == 0)      src = sum_i[2];
      else if (cfg_d_i == 0) src = sum_i[3];
      else                   src = gclk_i ^ gclk_inv_i;
      fire = (src == 1 && prev_m == 0);
      prev_m = src;
      d   = (cfg_a_i == 0) ? sum_i[0] : 0;
      k   = (cfg_b_i == 0) ? sum_i[1] : 0;
      pre = g_preset_i || (cfg_b_i == 1 && sum_i[1]);
      clr = g_reset_i  || (cfg_c_i == 1 && sum_i[2]);
      kind = cfg_dyn_i ? (g_tmode_i ? 1 : 0) : cfg_kind_i;
      if (clr)      q_m = 0;
      else if (pre) q_m = 1;
      else if (fire) begin
        if (kind == 1)      q_m = q_m ^ d;
        else if (kind == 2) begin
          if (d && k)  q_m = 1 - q_m;
          else if (d)  q_m = 1;
          else if (k)  q_m = 0;
        end
        else                q_m = d;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < 3; k++) begin
      logic pass, e;
      pass = (k == 0) ? cfg_a_i : (k == 1) ? cfg_b_i[1] : cfg_c_i[1];
      e = cfg_osel_i[k] ? (pass & sum_i[k]) : q_m[0];
      chk("R9", out_o[k], e);
    end
    chk("R10", oe_o, (cfg_d_i == 1) ? sum_i[3] : 1'b1);
    if (cfg_d_i[1]) chk("R11", fb_o, sum_i[3]);
    else            chk(focus, fb_o, q_m[0]);
  endtask

  // pct_ctl: chance (percent) of the global preset/reset lines pulsing
  task automatic run_phase(input string f, input int n, input int pct_ctl);
    focus = f;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      sum_i      = 4'($urandom_range(0, 15));
      gclk_i     = 1'($urandom_range(0, 1));
      g_tmode_i  = ($urandom_range(0, 7) == 0) ? ~g_tmode_i : g_tmode_i;
      g_preset_i = ($urandom_range(0, 99) < pct_ctl);
      g_reset_i  = ($urandom_range(0, 99) < pct_ctl);
    end
  endtask

  task automatic set_cfg(input logic dyn, input logic [1:0] kind, input logic a,
                         input logic [1:0] b, input logic [1:0] c, input logic [1:0] d,
                         input logic [2:0] osel, input logic inv);
    @(negedge clk);
    cfg_dyn_i = dyn; cfg_kind_i = kind; cfg_a_i = a; cfg_b_i = b;
    cfg_c_i = c; cfg_d_i = d; cfg_osel_i = osel; gclk_inv_i = inv;
    g_preset_i = 0; g_reset_i = 0;
  endtask

  initial begin
    rst_n = 0; sum_i = 4'hF; gclk_i = 1; gclk_inv_i = 0;
    g_preset_i = 0; g_reset_i = 0; g_tmode_i = 0;
    cfg_dyn_i = 0; cfg_kind_i = 0; cfg_a_i = 0; cfg_b_i = 0;
    cfg_c_i = 0; cfg_d_i = 0; cfg_osel_i = 3'b000;
    // R1: reset state, held under data that would load a 1
    repeat (3) @(negedge clk);
    chk("R1", out_o[0], 1'b0); chk("R1", out_o[2], 1'b0);
    chk("R1", oe_o, 1'b1);     chk("R1", fb_o, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", fb_o, 1'b0);

    set_cfg(0, 2'd0, 0, 2'd2, 2'd0, 2'd1, 3'b010, 0); run_phase("R3", 600, 0);
    set_cfg(0, 2'd3, 0, 2'd2, 2'd2, 2'd0, 3'b100, 0); run_phase("R3", 300, 0);
    set_cfg(0, 2'd1, 0, 2'd0, 2'd2, 2'd0, 3'b101, 0); run_phase("R4", 600, 0);
    set_cfg(0, 2'd2, 0, 2'd0, 2'd2, 2'd2, 3'b100, 1); run_phase("R5", 600, 0);
    set_cfg(0, 2'd2, 1, 2'd0, 2'd3, 2'd1, 3'b111, 0); run_phase("R5", 300, 0);
    set_cfg(1, 2'd2, 0, 2'd2, 2'd2, 2'd2, 3'b110, 0); run_phase("R6", 600, 0);
    set_cfg(0, 2'd0, 0, 2'd2, 2'd0, 2'd0, 3'b000, 0); run_phase("R2", 400, 0);
    set_cfg(0, 2'd1, 0, 2'd3, 2'd1, 2'd0, 3'b010, 1); run_phase("R2", 400, 0);
    set_cfg(0, 2'd1, 0, 2'd1, 2'd2, 2'd3, 3'b000, 0); run_phase("R7", 500, 10);
    set_cfg(0, 2'd2, 0, 2'd1, 2'd1, 2'd0, 3'b001, 1); run_phase("R8", 500, 15);

    // R8 over R7: both global lines at once, no cell clock activity
    set_cfg(0, 2'd0, 0, 2'd2, 2'd2, 2'd2, 3'b000, 0);
    sum_i = 4'b0000; g_preset_i = 1;
    @(negedge clk); chk("R7", out_o[0], 1'b1);
    g_reset_i = 1;
    @(negedge clk); chk("R8", out_o[0], 1'b0);
    g_reset_i = 0; g_preset_i = 0;

    // R2: a source held high gives only one edge; hold then drop
    set_cfg(0, 2'd1, 0, 2'd2, 2'd2, 2'd0, 3'b000, 0);
    sum_i = 4'b0001;
    @(negedge clk); chk("R2", out_o[0], q_m[0]);
    sum_i = 4'b1001;
    @(negedge clk); chk("R4", out_o[0], 1'b1);
    repeat (3) @(negedge clk);
    chk("R2", out_o[0], 1'b1);

    for (int r = 0; r < 20; r++) begin
      set_cfg(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
              3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      run_phase(cfg_dyn_i ? "R6" : "R3", 200, 3);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule